// File: doc/BRIEF.md
# Time-Multiplexed FIR Filter Engine

This block produces one FIR filter output for each accepted input sample, using one multiply-accumulate datapath that steps through the taps over successive clock cycles. Each accepted sample goes into a circular delay line. A coefficient store sits beside the delay line, and both stores are read in the same cycle. The fetched pair is registered, multiplied and added into a wide accumulator. When the last tap has been added, the sum is rounded, saturated to the sample width and presented with a one-cycle valid pulse.

The engine is busy from the cycle a sample is accepted until the cycle its result appears, and it ignores any sample offered while busy. Coefficients are written one at a time through an address/data/write-enable port, and these writes are accepted only while the engine is idle. Sample and coefficient words are signed two's complement. With the default scaling, a coefficient is a Q1.23 fraction, so a result word has the same format as a sample word.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, `y_o` is 0 and `busy_o` and `y_valid_o` are low. Reset also zeroes every delay-line entry, both pointers and every coefficient.
- R2: When `busy_o` is low and `smp_valid_i` is high at a clock edge, the sample is accepted and `busy_o` is high from that edge onward.
- R3: A sample offered while `busy_o` is high is dropped and never enters the delay line.
- R4: The accumulator starts at zero for every output, so one output's sum never carries into the next.
- R5: The output is the sum over k = 0..TAPS-1 of coef[k] * x[n-k], where x[n] is the newest accepted sample and coef[k] is the word written at address k.
- R6: `y_valid_o` is high for exactly one cycle, TAPS+2 edges after the accepting edge. `busy_o` falls at that same edge, and `y_o` holds its value until the next pulse.
- R7: Rounding adds 2^(SHIFT-1) to the accumulator and then shifts it arithmetically right by SHIFT, which is 23 by default. Ties therefore round toward +infinity.
- R8: The rounded value is clamped to the range [-2^23, 2^23-1].
- R9: Each 48-bit signed product is sign-extended into a 56-bit accumulator. A sequence of partial sums that exceeds the 48-bit range but ends in range gives the exact result.
- R10: A coefficient write is applied when `busy_o` is low and has no effect while `busy_o` is high.
- R11: The delay line wraps around. After more than TAPS samples, only the newest TAPS samples contribute to the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample offered |
| smp_data_i | input | DW (24) | Signed input sample |
| busy_o | output | 1 | A computation is in progress |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | $clog2(TAPS) | Tap index for the write |
| coef_data_i | input | CW (24) | Signed coefficient |
| y_o | output | DW (24) | Rounded, saturated result |
| y_valid_o | output | 1 | One-cycle result strobe |

## Verification
A scaled impulse followed by zeros reads the coefficient set back one tap at a time. This shows whether taps are paired with the right samples, whether the accumulator is cleared between outputs, and whether the pointer wraps correctly. Single-tap patterns placed just at and just beside the half-LSB boundary separate correct rounding from truncation or round-to-nearest-even. Full-scale inputs separate correct saturation in each direction from wraparound. A set of products whose partial sums reach 2^49 before cancelling shows whether the guard bits are present. A continuously held valid input and coefficient writes issued while busy show whether the drop rules are enforced. A long pseudo-random run then compares every cycle against an independent model.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DRAIN
  } fir_state_e;
endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int TAPS = 16,
  parameter int DW   = 24
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_i,
  input  logic [DW-1:0]               push_data_i,
  input  logic [$clog2(TAPS)-1:0]     tap_i,
  output logic [DW-1:0]               tap_data_o
);
  localparam int AW = $clog2(TAPS);

  logic [AW-1:0] wp_q, wp_nxt, rd_idx;
  logic [AW:0]   rd_sum;
  logic [DW-1:0] mem_q [TAPS];

  assign wp_nxt = (wp_q == AW'(TAPS-1)) ? '0 : wp_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      for (int i = 0; i < TAPS; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      wp_q          <= wp_nxt;
      mem_q[wp_nxt] <= push_data_i;
    end
  end

  // newest minus tap, modulo TAPS
  assign rd_sum = {1'b0, wp_q} + (AW+1)'(TAPS) - {1'b0, tap_i};
  assign rd_idx = (rd_sum >= (AW+1)'(TAPS)) ? AW'(rd_sum - (AW+1)'(TAPS)) : AW'(rd_sum);
  assign tap_data_o = mem_q[rd_idx];
endmodule

// File: rtl/fir_coef_store.sv
module fir_coef_store #(
  parameter int TAPS = 16,
  parameter int CW   = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [$clog2(TAPS)-1:0] wr_addr_i,
  input  logic [CW-1:0]           wr_data_i,
  input  logic [$clog2(TAPS)-1:0] rd_addr_i,
  output logic [CW-1:0]           rd_data_o
);
  localparam int AW = $clog2(TAPS);

  logic [CW-1:0] mem_q [TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) mem_q[i] <= '0;
    end else if (wr_en_i && ({1'b0, wr_addr_i} < (AW+1)'(TAPS))) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
  parameter int DW    = 24,
  parameter int CW    = 24,
  parameter int ACCW  = 56,
  parameter int SHIFT = 23,
  parameter int OW    = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 op_vld_i,
  input  logic                 op_last_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [CW-1:0] b_i,
  output logic                 fin_o,
  output logic [OW-1:0]        y_o,
  output logic                 y_valid_o
);
  localparam int PW = DW + CW;
  localparam logic signed [ACCW:0] HALF =
    $signed({{(ACCW+1-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}});
  localparam logic signed [ACCW:0] MAXV =
    $signed({{(ACCW+2-OW){1'b0}}, {(OW-1){1'b1}}});
  localparam logic signed [ACCW:0] MINV = ~MAXV;

  logic signed [PW-1:0]   a_ext, b_ext, prod;
  logic signed [ACCW-1:0] acc_q, prod_ext;
  logic signed [ACCW:0]   rnd, shr;
  logic [OW-1:0]          sat, y_q;
  logic                   fin_q, y_valid_q;

  assign a_ext    = $signed({{CW{a_i[DW-1]}}, a_i});
  assign b_ext    = $signed({{DW{b_i[CW-1]}}, b_i});
  assign prod     = a_ext * b_ext;
  assign prod_ext = $signed({{(ACCW-PW){prod[PW-1]}}, prod});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clr_i)    acc_q <= '0;
    else if (op_vld_i) acc_q <= acc_q + prod_ext;
  end

  assign rnd = $signed({acc_q[ACCW-1], acc_q}) + HALF;
  assign shr = rnd >>> SHIFT;

  always_comb begin
    if (shr > MAXV)      sat = MAXV[OW-1:0];
    else if (shr < MINV) sat = MINV[OW-1:0];
    else                 sat = shr[OW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_q     <= 1'b0;
      y_q       <= '0;
      y_valid_q <= 1'b0;
    end else begin
      fin_q     <= op_vld_i & op_last_i;
      y_valid_q <= fin_q;
      if (fin_q) y_q <= sat;
    end
  end

  assign fin_o     = fin_q;
  assign y_o       = y_q;
  assign y_valid_o = y_valid_q;
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_mac_pkg::*;
#(
  parameter int TAPS  = 16,
  parameter int DW    = 24,
  parameter int CW    = 24,
  parameter int ACCW  = 56,
  parameter int SHIFT = 23
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_valid_i,
  input  logic [DW-1:0]           smp_data_i,
  output logic                    busy_o,
  input  logic                    coef_we_i,
  input  logic [$clog2(TAPS)-1:0] coef_addr_i,
  input  logic [CW-1:0]           coef_data_i,
  output logic [DW-1:0]           y_o,
  output logic                    y_valid_o
);
  localparam int AW = $clog2(TAPS);

  fir_state_e     state_q;
  logic [AW-1:0]  k_q;
  logic           accept, idle, k_last, fin;
  logic [DW-1:0]  tap_data;
  logic [CW-1:0]  coef_data;
  logic signed [DW-1:0] d_q;
  logic signed [CW-1:0] c_q;
  logic           f_vld_q, f_last_q;

  assign idle   = (state_q == ST_IDLE);
  assign accept = idle && smp_valid_i;
  assign k_last = (k_q == AW'(TAPS-1));
  assign busy_o = !idle;

  fir_delay_line #(.TAPS(TAPS), .DW(DW)) u_dline (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (accept),
    .push_data_i (smp_data_i),
    .tap_i       (k_q),
    .tap_data_o  (tap_data)
  );

  fir_coef_store #(.TAPS(TAPS), .CW(CW)) u_coef (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (coef_we_i && idle),
    .wr_addr_i (coef_addr_i),
    .wr_data_i (coef_data_i),
    .rd_addr_i (k_q),
    .rd_data_o (coef_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      k_q      <= '0;
      d_q      <= '0;
      c_q      <= '0;
      f_vld_q  <= 1'b0;
      f_last_q <= 1'b0;
    end else begin
      f_vld_q  <= 1'b0;
      f_last_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          k_q <= '0;
          if (accept) state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          d_q      <= $signed(tap_data);
          c_q      <= $signed(coef_data);
          f_vld_q  <= 1'b1;
          f_last_q <= k_last;
          k_q      <= k_q + 1'b1;
          if (k_last) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (fin) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  fir_mac_unit #(
    .DW(DW), .CW(CW), .ACCW(ACCW), .SHIFT(SHIFT), .OW(DW)
  ) u_mac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .op_vld_i  (f_vld_q),
    .op_last_i (f_last_q),
    .a_i       (d_q),
    .b_i       (c_q),
    .fin_o     (fin),
    .y_o       (y_o),
    .y_valid_o (y_valid_o)
  );
endmodule

// File: rtl/fir_mac_engine_chk.sv
module fir_mac_engine_chk #(
  parameter int TAPS = 16,
  parameter int DW   = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_valid_i,
  input logic          busy_o,
  input logic [DW-1:0] y_o,
  input logic          y_valid_o
);
  int unsigned run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
    else             run_cnt <= 0;
  end

  a_r2_accept_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && smp_valid_i) |=> busy_o);

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |=> !y_valid_o);

  a_r6_idle_with_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> !busy_o);

  a_r6_busy_end_gives_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> y_valid_o);

  a_r6_output_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_valid_o |-> $stable(y_o));

  a_r6_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= TAPS + 2);
endmodule

bind fir_mac_engine fir_mac_engine_chk #(.TAPS(TAPS), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .busy_o      (busy_o),
  .y_o         (y_o),
  .y_valid_o   (y_valid_o)
);

// File: tb/fir_mac_engine_bench.sv
`timescale 1ns/1ps
module fir_mac_engine_bench;
  localparam int TAPS  = 16;
  localparam int DW    = 24;
  localparam int CW    = 24;
  localparam int SHIFT = 23;
  localparam int AW    = $clog2(TAPS);
  localparam longint MAXS = (64'sd1 <<< (DW-1)) - 1;
  localparam longint MINS = -(64'sd1 <<< (DW-1));

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          smp_valid_i = 1'b0;
  logic [DW-1:0] smp_data_i = '0;
  logic          busy_o;
  logic          coef_we_i = 1'b0;
  logic [AW-1:0] coef_addr_i = '0;
  logic [CW-1:0] coef_data_i = '0;
  logic [DW-1:0] y_o;
  logic          y_valid_o;

  always #2 clk_i = ~clk_i;

  fir_mac_engine #(.TAPS(TAPS), .DW(DW), .CW(CW), .ACCW(56), .SHIFT(SHIFT)) u_fir_mac_engine (
    .clk_i, .rst_ni, .smp_valid_i, .smp_data_i, .busy_o,
    .coef_we_i, .coef_addr_i, .coef_data_i, .y_o, .y_valid_o
  );

  int n_chk = 0;
  int n_fail = 0;
  string phase = "R5";

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  longint m_hist[$];
  longint m_coef[TAPS];
  int     m_cnt;
  bit     m_exp_vld;
  longint m_pend, m_last_y;

  function automatic longint ref_out();
    longint acc, r;
    acc = 0;
    for (int k = 0; k < TAPS; k++) acc += m_coef[k] * m_hist[k];
    r = (acc + (64'sd1 <<< (SHIFT-1))) >>> SHIFT;
    if (r > MAXS) r = MAXS;
    if (r < MINS) r = MINS;
    return r;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_hist.delete();
      for (int k = 0; k < TAPS; k++) m_hist.push_back(0);
      for (int k = 0; k < TAPS; k++) m_coef[k] = 0;
      m_cnt = 0; m_exp_vld = 0; m_pend = 0; m_last_y = 0;
    end else begin
      m_exp_vld = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_exp_vld = 1;
          m_last_y  = m_pend;
        end
      end else begin
        if (coef_we_i) m_coef[coef_addr_i] = longint'($signed(coef_data_i));
        if (smp_valid_i) begin
          m_hist.push_front(longint'($signed(smp_data_i)));
          void'(m_hist.pop_back());
          m_pend = ref_out();
          m_cnt  = TAPS + 2;
        end
      end
    end
  end

  always @(posedge clk_i) begin
    #1;
    if (rst_ni) begin
      chk(busy_o == (m_cnt != 0), "R2 busy", longint'(busy_o), longint'(m_cnt != 0));
      chk(y_valid_o == m_exp_vld, "R6 valid", longint'(y_valid_o), longint'(m_exp_vld));
      if (m_exp_vld)
        chk(longint'($signed(y_o)) == m_last_y, phase, longint'($signed(y_o)), m_last_y);
      else
        chk(longint'($signed(y_o)) == m_last_y, "R6 hold", longint'($signed(y_o)), m_last_y);
    end
  end

  task automatic wait_idle();
    while (m_cnt != 0) @(negedge clk_i);
  endtask

  task automatic send(longint x);
    @(negedge clk_i);
    smp_valid_i = 1'b1;
    smp_data_i  = DW'(x);
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    wait_idle();
  endtask

  task automatic load_coef(int k, longint v);
    @(negedge clk_i);
    coef_we_i   = 1'b1;
    coef_addr_i = AW'(k);
    coef_data_i = CW'(v);
    @(negedge clk_i);
    coef_we_i = 1'b0;
  endtask

  task automatic load_all(longint v);
    for (int k = 0; k < TAPS; k++) load_coef(k, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state at the ports
    chk(y_o == '0, "R1 y", longint'(y_o), 0);
    chk(!busy_o, "R1 busy", longint'(busy_o), 0);
    chk(!y_valid_o, "R1 valid", longint'(y_valid_o), 0);

    phase = "R1 zero coefs";
    send(MAXS);
    for (int k = 0; k < TAPS; k++) load_coef(k, (k + 1) * 64'sd300001 - 64'sd2000000);
    phase = "R1 cleared line";
    send(64'sd1 <<< 22);

    // R4: impulse then zeros, output walks the coefficients
    phase = "R4";
    for (int i = 0; i < TAPS + 2; i++) send(0);
    send(64'sd1 <<< 22);
    for (int i = 0; i < TAPS + 3; i++) send(0);

    // R5 and R11: varied samples, more than TAPS to force wrap
    phase = "R5";
    send(-3 * (64'sd1 <<< 20));
    send(5 * (64'sd1 <<< 19));
    send(-64'sd77777);
    phase = "R11";
    for (int i = 0; i < 2 * TAPS + 5; i++) send((i * 64'sd123457) % 64'sd4000000 - 64'sd1900000);

    // R3: valid held high through busy windows
    phase = "R3";
    @(negedge clk_i);
    for (int i = 0; i < 3 * (TAPS + 2) + 5; i++) begin
      smp_valid_i = 1'b1;
      smp_data_i  = DW'(i * 64'sd51234 - 64'sd700000);
      @(negedge clk_i);
    end
    smp_valid_i = 1'b0;
    wait_idle();
    send(64'sd12345);

    // R10: write while busy is dropped, idle write takes effect
    phase = "R10";
    @(negedge clk_i);
    smp_valid_i = 1'b1;
    smp_data_i  = DW'(64'sd1 <<< 21);
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    coef_we_i   = 1'b1;
    coef_addr_i = '0;
    coef_data_i = CW'(MAXS);
    @(negedge clk_i);
    coef_we_i = 1'b0;
    wait_idle();
    send(64'sd1 <<< 21);
    load_coef(0, -64'sd4000000);
    send(64'sd1 <<< 21);

    // R7: single-tap rounding at the half-LSB boundary
    phase = "R7";
    load_all(0);
    load_coef(0, 1);
    send(64'sd1 <<< 22);
    send((64'sd1 <<< 22) - 1);
    send(-(64'sd1 <<< 22));
    send(-(64'sd1 <<< 22) - 1);
    send((64'sd3 <<< 22) - 64'sd4000000);

    // R8: saturation both ways
    phase = "R8";
    load_all(MAXS);
    for (int i = 0; i < TAPS; i++) send(MAXS);
    load_all(MINS);
    send(MAXS);

    // R9: partial sums beyond 48 bits that cancel
    phase = "R9";
    for (int i = 0; i < TAPS / 2; i++) send(MAXS);
    for (int i = 0; i < TAPS / 2; i++) send(MINS);
    send(MINS);

    // R5: pseudo-random run
    phase = "R5 random";
    for (int k = 0; k < TAPS; k++)
      load_coef(k, longint'($signed(20'($urandom))));
    for (int i = 0; i < 60; i++)
      send(longint'($signed(24'($urandom))));

    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule